// File: doc/BRIEF.md
# Interleaved Write Data Reassembler

This block sits on a write path between an upstream port whose write data beats are tagged with a transaction ID and may interleave across several open bursts, and a downstream port that needs every burst's data in one contiguous run with no ID on the data channel. A write address is forwarded downstream in the same cycle it is accepted, and it takes one slot in a small circular table. Each slot has a beat buffer large enough for the longest 16-beat burst. Incoming beats are matched by ID to an open slot and stored there. The oldest slot is drained downstream in address order, and the downstream last flag comes from the stored burst length.

Only the `DEPTH` oldest held slots accept data, which sets the interleaving depth the upstream side must respect. When several open bursts share an ID, beats go to the oldest of them. An upstream last flag that does not match the burst length sets a sticky error flag, and the burst still goes out with the length from its address. Write responses pass back untouched.

Top module: `wr_deinterleaver`

## Requirements
- R1: After reset no slot is held: `s_wready` and `m_wvalid` are 0, `proto_err` is 0, and `s_awready` follows `m_awready`.
- R2: A write address is accepted upstream only in a cycle where it is also accepted downstream, so `m_awvalid` with the same ID, address and length accompanies every upstream address handshake.
- R3: There are `SLOTS` slots. A slot is held from its address handshake until its last beat is accepted downstream, and `s_awready` is 0 while all slots are held.
- R4: A beat is accepted only if its WID matches one of the `DEPTH` oldest held slots that still lacks beats. A beat whose WID matches only a younger slot, or no held slot at all, sees `s_wready` low.
- R5: When two or more open bursts share an ID, each accepted beat is stored in the oldest of them that has not yet received all its beats.
- R6: Downstream bursts leave in address acceptance order. Each burst is contiguous, its beats keep their upstream order, and data and byte strobes (one strobe bit per byte lane) are unchanged.
- R7: A burst with length field L produces L+1 downstream beats, and `m_wlast` is 1 on the last of them only.
- R8: An accepted beat whose `s_wlast` differs from (beat index == L) sets `proto_err`, which then stays 1 until reset.
- R9: Write responses pass straight through: `s_bvalid`, `s_bid` and `s_bresp` equal the downstream response inputs, and `m_bready` equals `s_bready`.
- R10: While `m_wvalid` is 1 and `m_wready` is 0, `m_wvalid`, `m_wdata`, `m_wstrb` and `m_wlast` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_awvalid | input | 1 | Upstream address valid |
| s_awready | output | 1 | Upstream address ready |
| s_awid | input | ID_W | Upstream address ID |
| s_awaddr | input | ADDR_W | Upstream burst start address |
| s_awlen | input | 4 | Upstream burst length minus one |
| s_wvalid | input | 1 | Upstream data valid |
| s_wready | output | 1 | Upstream data ready |
| s_wid | input | ID_W | Upstream data ID |
| s_wdata | input | DATA_W | Upstream data |
| s_wstrb | input | DATA_W/8 | Upstream byte strobes |
| s_wlast | input | 1 | Upstream last-beat flag (checked only) |
| s_bvalid | output | 1 | Upstream response valid |
| s_bready | input | 1 | Upstream response ready |
| s_bid | output | ID_W | Upstream response ID |
| s_bresp | output | 2 | Upstream response code |
| m_awvalid | output | 1 | Downstream address valid |
| m_awready | input | 1 | Downstream address ready |
| m_awid | output | ID_W | Downstream address ID |
| m_awaddr | output | ADDR_W | Downstream start address |
| m_awlen | output | 4 | Downstream burst length minus one |
| m_wvalid | output | 1 | Downstream data valid |
| m_wready | input | 1 | Downstream data ready |
| m_wdata | output | DATA_W | Downstream data |
| m_wstrb | output | DATA_W/8 | Downstream byte strobes |
| m_wlast | output | 1 | Downstream last beat, from the stored length |
| m_bvalid | input | 1 | Downstream response valid |
| m_bready | output | 1 | Downstream response ready |
| m_bid | input | ID_W | Downstream response ID |
| m_bresp | input | 2 | Downstream response code |
| proto_err | output | 1 | Sticky last-flag mismatch |

## Verification
Some properties are checked on every cycle. Address forwarding must coincide with upstream acceptance. Address ready must stay low while the slot table is full, and occupancy must drop when a last beat leaves. Downstream data must hold while stalled, the error flag must stay sticky, and data ready must never rise with no slot held. Other behaviour can only be shown by the directed scenarios, because it depends on what was sent earlier. These are the reordering of interleaved beats into contiguous bursts, the refusal of beats for slots outside the depth window, the assignment of same-ID beats to the oldest open burst, and the last-flag and strobe contents of each rebuilt burst.

// File: rtl/wdi_pkg.sv
package wdi_pkg;
  // Burst length field is four bits wide, so a burst has at most 16 beats.
  localparam int LEN_W     = 4;
  localparam int MAX_BEATS = 1 << LEN_W;
  localparam int CNT_W     = LEN_W + 1;

  typedef struct packed {
    logic [LEN_W-1:0] len;  // beats minus one
    logic [CNT_W-1:0] rcv;  // beats stored so far
  } slot_cnt_t;
endpackage

// File: rtl/wdi_slot_table.sv
module wdi_slot_table
  import wdi_pkg::*;
#(
  parameter int SLOTS = 4,
  parameter int ID_W  = 4,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int OCC_W  = SLOT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_i,
  input  logic [ID_W-1:0]   alloc_id_i,
  input  logic [LEN_W-1:0]  alloc_len_i,
  input  logic              fill_i,
  input  logic [SLOT_W-1:0] fill_slot_i,
  input  logic              beat_i,
  input  logic              drain_i,
  output logic [SLOT_W-1:0] head_o,
  output logic [OCC_W-1:0]  occ_o,
  output logic [ID_W-1:0]   id_o  [SLOTS],
  output slot_cnt_t         cnt_o [SLOTS],
  output logic [LEN_W-1:0]  rd_ptr_o
);
  logic [SLOT_W-1:0] head_q, head_n, tail;
  logic [OCC_W-1:0]  occ_q, occ_n;
  logic [LEN_W-1:0]  rd_q, rd_n;
  logic [ID_W-1:0]   id_q [SLOTS];
  logic [ID_W-1:0]   id_n [SLOTS];
  slot_cnt_t         cnt_q [SLOTS];
  slot_cnt_t         cnt_n [SLOTS];

  assign tail = head_q + occ_q[SLOT_W-1:0];

  always_comb begin
    head_n = head_q;
    occ_n  = occ_q;
    rd_n   = rd_q;
    id_n   = id_q;
    cnt_n  = cnt_q;
    if (alloc_i) begin
      id_n[tail]     = alloc_id_i;
      cnt_n[tail]    = '{len: alloc_len_i, rcv: '0};
    end
    if (fill_i) cnt_n[fill_slot_i].rcv = cnt_q[fill_slot_i].rcv + CNT_W'(1);
    if (beat_i) rd_n = drain_i ? '0 : rd_q + LEN_W'(1);
    if (drain_i) head_n = head_q + SLOT_W'(1);
    occ_n = occ_q + OCC_W'(alloc_i) - OCC_W'(drain_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      occ_q  <= '0;
      rd_q   <= '0;
      for (int i = 0; i < SLOTS; i++) begin
        id_q[i]  <= '0;
        cnt_q[i] <= '0;
      end
    end else begin
      if (drain_i) head_q <= head_n;
      if (alloc_i || drain_i) occ_q <= occ_n;
      if (beat_i) rd_q <= rd_n;
      if (alloc_i || fill_i) begin
        id_q  <= id_n;
        cnt_q <= cnt_n;
      end
    end
  end

  assign head_o   = head_q;
  assign occ_o    = occ_q;
  assign id_o     = id_q;
  assign cnt_o    = cnt_q;
  assign rd_ptr_o = rd_q;
endmodule

// File: rtl/wdi_match.sv
module wdi_match
  import wdi_pkg::*;
#(
  parameter int SLOTS = 4,
  parameter int DEPTH = 2,
  parameter int ID_W  = 4,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int OCC_W  = SLOT_W + 1
) (
  input  logic [SLOT_W-1:0] head_i,
  input  logic [OCC_W-1:0]  occ_i,
  input  logic [ID_W-1:0]   id_i  [SLOTS],
  input  slot_cnt_t         cnt_i [SLOTS],
  input  logic [ID_W-1:0]   wid_i,
  output logic              hit_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [LEN_W-1:0]  beat_o,
  output logic              exp_last_o
);
  localparam int WIN = (DEPTH < SLOTS) ? DEPTH : SLOTS;

  logic [WIN-1:0]    cand;
  logic [SLOT_W-1:0] pos_slot [WIN];

  for (genvar k = 0; k < WIN; k++) begin : g_win
    logic open;
    assign pos_slot[k] = head_i + SLOT_W'(k);
    assign open = cnt_i[pos_slot[k]].rcv != (CNT_W'(cnt_i[pos_slot[k]].len) + CNT_W'(1));
    assign cand[k] = (OCC_W'(k) < occ_i) && open && (id_i[pos_slot[k]] == wid_i);
  end

  always_comb begin
    hit_o  = 1'b0;
    slot_o = head_i;
    for (int k = WIN - 1; k >= 0; k--) begin
      if (cand[k]) begin
        hit_o  = 1'b1;
        slot_o = pos_slot[k];
      end
    end
    beat_o     = cnt_i[slot_o].rcv[LEN_W-1:0];
    exp_last_o = beat_o == cnt_i[slot_o].len;
  end
endmodule

// File: rtl/wdi_beat_store.sv
module wdi_beat_store
  import wdi_pkg::*;
#(
  parameter int SLOTS  = 4,
  parameter int DATA_W = 32,
  localparam int STRB_W = DATA_W / 8,
  localparam int AW     = $clog2(SLOTS) + LEN_W
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [STRB_W-1:0] wstrb_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [STRB_W-1:0] rstrb_o
);
  localparam int ENTRIES = SLOTS * MAX_BEATS;

  logic [STRB_W+DATA_W-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= {wstrb_i, wdata_i};
  end

  assign {rstrb_o, rdata_o} = mem[raddr_i];
endmodule

// File: rtl/wr_deinterleaver.sv
module wr_deinterleaver
  import wdi_pkg::*;
#(
  parameter int ID_W   = 4,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SLOTS  = 4,
  parameter int DEPTH  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                s_awvalid,
  output logic                s_awready,
  input  logic [ID_W-1:0]     s_awid,
  input  logic [ADDR_W-1:0]   s_awaddr,
  input  logic [3:0]          s_awlen,
  input  logic                s_wvalid,
  output logic                s_wready,
  input  logic [ID_W-1:0]     s_wid,
  input  logic [DATA_W-1:0]   s_wdata,
  input  logic [DATA_W/8-1:0] s_wstrb,
  input  logic                s_wlast,
  output logic                s_bvalid,
  input  logic                s_bready,
  output logic [ID_W-1:0]     s_bid,
  output logic [1:0]          s_bresp,
  output logic                m_awvalid,
  input  logic                m_awready,
  output logic [ID_W-1:0]     m_awid,
  output logic [ADDR_W-1:0]   m_awaddr,
  output logic [3:0]          m_awlen,
  output logic                m_wvalid,
  input  logic                m_wready,
  output logic [DATA_W-1:0]   m_wdata,
  output logic [DATA_W/8-1:0] m_wstrb,
  output logic                m_wlast,
  input  logic                m_bvalid,
  output logic                m_bready,
  input  logic [ID_W-1:0]     m_bid,
  input  logic [1:0]          m_bresp,
  output logic                proto_err
);
  localparam int STRB_W = DATA_W / 8;
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int OCC_W  = SLOT_W + 1;
  localparam logic [OCC_W-1:0] FULL_OCC = OCC_W'(SLOTS);

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [SLOT_W-1:0] head, fill_slot;
  logic [OCC_W-1:0]  occupied;
  logic [ID_W-1:0]   slot_id  [SLOTS];
  slot_cnt_t         slot_cnt [SLOTS];
  logic [LEN_W-1:0]  rd_ptr, fill_beat;
  logic              hit, exp_last, alloc, fill, beat, drain, full;
  logic              err_q, err_n;

  // Address path: forwarded at acceptance, gated by free slot.
  assign full      = occupied == FULL_OCC;
  assign m_awvalid = s_awvalid && !full;
  assign s_awready = m_awready && !full;
  assign m_awid    = s_awid;
  assign m_awaddr  = s_awaddr;
  assign m_awlen   = s_awlen;
  assign alloc     = s_awvalid && s_awready;

  wdi_match #(.SLOTS(SLOTS), .DEPTH(DEPTH), .ID_W(ID_W)) match_i (
    .head_i(head), .occ_i(occupied), .id_i(slot_id), .cnt_i(slot_cnt),
    .wid_i(s_wid), .hit_o(hit), .slot_o(fill_slot), .beat_o(fill_beat),
    .exp_last_o(exp_last)
  );

  assign s_wready = hit;
  assign fill     = s_wvalid && hit;

  // Drain path: oldest slot, beats already stored.
  assign m_wvalid = (occupied != '0) && (CNT_W'(rd_ptr) < slot_cnt[head].rcv);
  assign m_wlast  = rd_ptr == slot_cnt[head].len;
  assign beat     = m_wvalid && m_wready;
  assign drain    = beat && m_wlast;

  wdi_slot_table #(.SLOTS(SLOTS), .ID_W(ID_W)) table_i (
    .clk(clk), .rst_n(rst_int_n),
    .alloc_i(alloc), .alloc_id_i(s_awid), .alloc_len_i(s_awlen),
    .fill_i(fill), .fill_slot_i(fill_slot),
    .beat_i(beat), .drain_i(drain),
    .head_o(head), .occ_o(occupied), .id_o(slot_id), .cnt_o(slot_cnt),
    .rd_ptr_o(rd_ptr)
  );

  wdi_beat_store #(.SLOTS(SLOTS), .DATA_W(DATA_W)) store_i (
    .clk(clk), .we_i(fill),
    .waddr_i({fill_slot, fill_beat}), .wdata_i(s_wdata), .wstrb_i(s_wstrb),
    .raddr_i({head, rd_ptr}), .rdata_o(m_wdata), .rstrb_o(m_wstrb)
  );

  // Sticky last-flag mismatch.
  always_comb err_n = err_q | (fill && (s_wlast != exp_last));

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) err_q <= 1'b0;
    else if (fill)  err_q <= err_n;
  end
  assign proto_err = err_q;

  // Response path.
  assign s_bvalid = m_bvalid;
  assign s_bid    = m_bid;
  assign s_bresp  = m_bresp;
  assign m_bready = s_bready;
endmodule

// File: rtl/wdi_checker.sv
module wdi_checker #(
  parameter int SLOTS  = 4,
  parameter int OCC_W  = 3,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              s_awvalid,
  input logic              s_awready,
  input logic              m_awvalid,
  input logic              m_awready,
  input logic              s_wready,
  input logic              m_wvalid,
  input logic              m_wready,
  input logic [DATA_W-1:0] m_wdata,
  input logic [DATA_W/8-1:0] m_wstrb,
  input logic              m_wlast,
  input logic              proto_err,
  input logic [OCC_W-1:0]  occupied
);
  localparam logic [OCC_W-1:0] FULL_OCC = OCC_W'(SLOTS);

  AST_AW_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
    s_awvalid && s_awready |-> m_awvalid && m_awready); // R2
  AST_AW_FULL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    occupied == FULL_OCC |-> !s_awready); // R3
  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    occupied <= FULL_OCC); // R3
  AST_SLOT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    m_wvalid && m_wready && m_wlast && !(s_awvalid && s_awready)
    |=> occupied == $past(occupied) - OCC_W'(1)); // R3
  AST_WREADY_NEEDS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    s_wready |-> occupied != '0); // R4
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err); // R8
  AST_W_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    m_wvalid && !m_wready |=> m_wvalid && $stable(m_wdata) && $stable(m_wstrb)
    && $stable(m_wlast)); // R10
endmodule

bind wr_deinterleaver wdi_checker #(
  .SLOTS(SLOTS), .OCC_W(OCC_W), .DATA_W(DATA_W)
) chk_i (
  .clk(clk), .rst_n(rst_n),
  .s_awvalid(s_awvalid), .s_awready(s_awready),
  .m_awvalid(m_awvalid), .m_awready(m_awready),
  .s_wready(s_wready), .m_wvalid(m_wvalid), .m_wready(m_wready),
  .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_wlast(m_wlast),
  .proto_err(proto_err), .occupied(occupied)
);

// File: tb/wr_deinterleaver_tb_top.sv
`timescale 1ns/1ps
module wr_deinterleaver_tb_top;
  localparam int ID_W = 4, ADDR_W = 32, DATA_W = 32, SLOTS = 4, DEPTH = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic s_awvalid, s_awready, s_wvalid, s_wready, s_wlast;
  logic [ID_W-1:0] s_awid, s_wid, s_bid, m_awid, m_bid;
  logic [ADDR_W-1:0] s_awaddr, m_awaddr;
  logic [3:0] s_awlen, m_awlen;
  logic [DATA_W-1:0] s_wdata, m_wdata;
  logic [3:0] s_wstrb, m_wstrb;
  logic s_bvalid, s_bready, m_awvalid, m_awready, m_wvalid, m_wready, m_wlast;
  logic m_bvalid, m_bready, proto_err;
  logic [1:0] s_bresp, m_bresp;

  always #2.5 clk = ~clk;

  wr_deinterleaver #(.ID_W(ID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
                     .SLOTS(SLOTS), .DEPTH(DEPTH)) dut_i (.*);

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // Downstream beat recorder.
  int got_n = 0;
  logic [31:0] got_d [0:255];
  logic [3:0]  got_s [0:255];
  logic        got_l [0:255];
  always @(negedge clk) begin
    if (rst_n && m_wvalid && m_wready && got_n < 256) begin
      got_d[got_n] = m_wdata;
      got_s[got_n] = m_wstrb;
      got_l[got_n] = m_wlast;
      got_n = got_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] dv(input int id, input int n);
    return 32'hD000_0000 | (id << 8) | n;
  endfunction

  task automatic send_aw(input int id, input int addr, input int len);
    @(posedge clk); #1;
    s_awvalid = 1; s_awid = ID_W'(id); s_awaddr = addr; s_awlen = 4'(len);
    for (int t = 0; t < 200; t++) begin
      @(negedge clk);
      if (s_awready) begin
        chk(m_awvalid && m_awaddr == addr && m_awlen == 4'(len) && m_awid == ID_W'(id),
            "R2", m_awaddr, addr);
        break;
      end
    end
    @(posedge clk); #1;
    s_awvalid = 0;
  endtask

  task automatic send_w(input int id, input logic [31:0] d, input logic [3:0] st,
                        input bit last);
    @(posedge clk); #1;
    s_wvalid = 1; s_wid = ID_W'(id); s_wdata = d; s_wstrb = st; s_wlast = last;
    for (int t = 0; t < 200; t++) begin
      @(negedge clk);
      if (s_wready) break;
    end
    @(posedge clk); #1;
    s_wvalid = 0;
  endtask

  // Offer a beat that must be refused, then withdraw it.
  task automatic refuse_w(input int id, input string req);
    @(posedge clk); #1;
    s_wvalid = 1; s_wid = ID_W'(id); s_wdata = 32'hBAD; s_wstrb = 4'hF; s_wlast = 1;
    repeat (4) @(negedge clk);
    chk(!s_wready, req, s_wready, 0);
    @(posedge clk); #1;
    s_wvalid = 0;
  endtask

  task automatic wait_got(input int target);
    for (int t = 0; t < 300 && got_n < target; t++) @(negedge clk);
  endtask

  task automatic chk_beat(input int idx, input logic [31:0] d, input logic [3:0] st,
                          input bit last, input string req);
    chk(idx < got_n, req, got_n, idx + 1);
    chk(got_d[idx] == d && got_s[idx] == st && got_l[idx] == last, req,
        {got_l[idx], got_s[idx], got_d[idx][23:0]}, {last, st, d[23:0]});
  endtask

  task automatic set_mready(input bit v);
    @(posedge clk); #1;
    m_wready = v;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(s_awready == 1, "R1", s_awready, 1);
    chk(s_wready == 0, "R1", s_wready, 0);
    chk(m_wvalid == 0, "R1", m_wvalid, 0);
    chk(proto_err == 0, "R1", proto_err, 0);
  endtask

  task automatic t_interleave;
    int b = got_n;
    send_aw(1, 'h100, 1);
    send_aw(2, 'h200, 1);
    send_w(2, dv(2, 0), 4'hF, 0);
    send_w(1, dv(1, 0), 4'h3, 0);
    send_w(2, dv(2, 1), 4'hC, 1);
    send_w(1, dv(1, 1), 4'h5, 1);
    wait_got(b + 4);
    chk_beat(b + 0, dv(1, 0), 4'h3, 0, "R6");
    chk_beat(b + 1, dv(1, 1), 4'h5, 1, "R7");
    chk_beat(b + 2, dv(2, 0), 4'hF, 0, "R6");
    chk_beat(b + 3, dv(2, 1), 4'hC, 1, "R7");
  endtask

  task automatic t_depth;
    int b = got_n;
    set_mready(0);
    refuse_w(14, "R4");            // no held slot at all
    send_aw(3, 'h300, 0);
    send_aw(4, 'h400, 0);
    send_aw(5, 'h500, 0);
    refuse_w(5, "R4");             // third slot outside depth two
    send_w(3, dv(3, 0), 4'h1, 1);
    send_w(4, dv(4, 0), 4'h2, 1);
    refuse_w(5, "R4");             // older slots full but not yet drained
    set_mready(1);
    send_w(5, dv(5, 0), 4'h4, 1);
    wait_got(b + 3);
    chk_beat(b + 0, dv(3, 0), 4'h1, 1, "R4");
    chk_beat(b + 1, dv(4, 0), 4'h2, 1, "R6");
    chk_beat(b + 2, dv(5, 0), 4'h4, 1, "R4");
  endtask

  task automatic t_sameid;
    int b = got_n;
    set_mready(0);
    send_aw(6, 'h600, 1);
    send_aw(6, 'h640, 0);
    send_w(6, dv(6, 0), 4'hF, 0);
    send_w(6, dv(6, 1), 4'hE, 1);
    send_w(6, dv(6, 2), 4'h7, 1);
    set_mready(1);
    wait_got(b + 3);
    chk_beat(b + 0, dv(6, 0), 4'hF, 0, "R5");
    chk_beat(b + 1, dv(6, 1), 4'hE, 1, "R5");
    chk_beat(b + 2, dv(6, 2), 4'h7, 1, "R5");
  endtask

  task automatic t_full;
    int b = got_n;
    set_mready(0);
    for (int i = 1; i <= SLOTS; i++) send_aw(i, 'h1000 * i, 0);
    @(posedge clk); #1;
    s_awvalid = 1; s_awid = 8; s_awaddr = 'h8000; s_awlen = 0;
    repeat (3) @(negedge clk);
    chk(!s_awready, "R3", s_awready, 0);
    chk(!m_awvalid, "R3", m_awvalid, 0);
    @(posedge clk); #1;
    s_awvalid = 0;
    send_w(1, dv(1, 9), 4'hF, 1);
    send_w(2, dv(2, 9), 4'hF, 1);
    set_mready(1);
    wait_got(b + 2);
    @(negedge clk);
    chk(s_awready, "R3", s_awready, 1);
    send_w(3, dv(3, 9), 4'hF, 1);
    send_w(4, dv(4, 9), 4'hF, 1);
    wait_got(b + 4);
    chk_beat(b + 3, dv(4, 9), 4'hF, 1, "R6");
  endtask

  task automatic t_stall;
    int b = got_n;
    logic [31:0] held;
    set_mready(0);
    send_aw(9, 'h900, 1);
    send_w(9, dv(9, 0), 4'hA, 0);
    send_w(9, dv(9, 1), 4'h6, 1);
    @(negedge clk);
    held = m_wdata;
    chk(m_wvalid && held == dv(9, 0), "R10", held, dv(9, 0));
    repeat (3) @(negedge clk);
    chk(m_wvalid && m_wdata == held && m_wstrb == 4'hA && !m_wlast, "R10", m_wdata, held);
    set_mready(1);
    wait_got(b + 2);
    chk_beat(b + 1, dv(9, 1), 4'h6, 1, "R6");
  endtask

  task automatic t_bresp;
    @(posedge clk); #1;
    m_bvalid = 1; m_bid = 5; m_bresp = 2'b10; s_bready = 0;
    @(negedge clk);
    chk(s_bvalid && s_bid == 5 && s_bresp == 2'b10, "R9", {s_bvalid, s_bid, s_bresp}, 7'h56);
    chk(!m_bready, "R9", m_bready, 0);
    @(posedge clk); #1;
    s_bready = 1;
    @(negedge clk);
    chk(m_bready, "R9", m_bready, 1);
    @(posedge clk); #1;
    m_bvalid = 0; s_bready = 0;
  endtask

  task automatic t_lasterr;
    int b = got_n;
    chk(!proto_err, "R8", proto_err, 0);
    send_aw(7, 'h700, 2);
    send_w(7, dv(7, 0), 4'hF, 0);
    send_w(7, dv(7, 1), 4'hF, 1);  // early last
    send_w(7, dv(7, 2), 4'hF, 0);  // missing last
    wait_got(b + 3);
    chk(proto_err, "R8", proto_err, 1);
    chk_beat(b + 1, dv(7, 1), 4'hF, 0, "R7");
    chk_beat(b + 2, dv(7, 2), 4'hF, 1, "R7");
    repeat (3) @(negedge clk);
    chk(proto_err, "R8", proto_err, 1);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    rst_n = 0;
    s_awvalid = 0; s_awid = 0; s_awaddr = 0; s_awlen = 0;
    s_wvalid = 0; s_wid = 0; s_wdata = 0; s_wstrb = 0; s_wlast = 0;
    s_bready = 0; m_awready = 1; m_wready = 1;
    m_bvalid = 0; m_bid = 0; m_bresp = 0;
    repeat (5) @(posedge clk);
    #1 rst_n = 1;
    repeat (5) @(posedge clk);
    t_reset();
    t_interleave();
    t_depth();
    t_sameid();
    t_full();
    t_stall();
    t_bresp();
    t_lasterr();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule